// File: doc/BRIEF.md
# Per-Frame Clock Level Selector

This block chooses a processor clock step for every video frame before it is decoded. Each frame hint arrives over a valid/ready handshake and carries a type code (intra, predicted or bi-predicted) and the frame's encoded size in bits. For each type, three size thresholds split the size range into four bands. A table of step indices, also supplied on ports, names the step for each band. When the chosen step is not the one already in force, the block raises a one-cycle change request that carries the new step.

While a frame is being decoded, the block counts timer ticks until the decoder signals completion. If the frame ran past the programmed frame period (67 ticks for 15 frames per second with a 1 kHz tick), the overrun is added to a saturating total of missed time. Software reads this total at the end of the run. A hint can be marked as the last frame of the run. When that frame completes, the block drops back to the lowest step.

Top module: `frame_step_sel`

## Requirements
- R1: After reset the current step is 0, no request is raised, the miss total is 0 and the hint port is ready.
- R2: A frame's band is the count of its type's three thresholds that the size equals or exceeds (unsigned), giving 0 to 3. The step is the table entry for that type and band. Type codes are 0 intra, 1 predicted, 2 bi-predicted. Threshold k of type t sits at bits (3t+k)*SIZE_W. The step for band b of type t sits at bits (4t+b)*STEP_W.
- R3: For a bi-predicted frame the step is the larger of its own table entry and the predicted-type entry at the same size. Code 3 is handled as bi-predicted.
- R4: In the cycle after a hint is accepted, the request strobe is high for one cycle exactly when the new step differs from the current one. The request step and the current step then both show the new step. If the steps match, the current step is unchanged and no strobe is raised.
- R5: The hint port drops ready in the cycle after acceptance and stays low until the done strobe. Hints offered meanwhile change neither the step nor the request.
- R6: The elapsed time of a frame is the number of tick pulses sampled strictly after the acceptance cycle and strictly before the done cycle. If elapsed exceeds the period, the done edge adds elapsed minus period to the miss total, saturating at all ones. Otherwise the total is unchanged.
- R7: When a frame marked last completes, the current step returns to 0. A request for step 0 is strobed only if the step was not already 0.
- R8: A done strobe while no frame is pending changes neither the miss total nor the step, and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hint_valid_i | input | 1 | Frame hint offered |
| hint_ready_o | output | 1 | Hint accepted when high with valid |
| hint_type_i | input | 2 | Frame type code |
| hint_size_i | input | SIZE_W | Encoded frame size in bits |
| hint_last_i | input | 1 | Frame is the final one of the run |
| done_i | input | 1 | Decoder finished the pending frame |
| tick_i | input | 1 | Timer tick pulse |
| period_i | input | PER_W | Frame period in ticks |
| thr_i | input | 9*SIZE_W | Size thresholds, three per type |
| step_tbl_i | input | 12*STEP_W | Step per type and band |
| req_valid_o | output | 1 | One-cycle step change request |
| req_step_o | output | STEP_W | Requested step |
| cur_step_o | output | STEP_W | Step currently in force |
| miss_total_o | output | MISS_W | Accumulated missed time in ticks |

## Verification
The bench sweeps every size of a narrow size field for all four type codes. This exposes wrong comparison direction, off-by-one band edges and a missing bi-predicted floor, because the predicted table is set to exceed the bi-predicted one in some bands. Tick counts vary from frame to frame, landing below, at and above the period, so the at-period case separates a strict overrun test from an inclusive one. Steps repeat between adjacent sizes, so both the strobe and no-strobe cases of a change request are covered. Hints offered while busy, a stray done while idle, and a final frame check the step return and the paths that must be ignored.

// File: rtl/frame_step_pkg.sv
package frame_step_pkg;
  localparam int unsigned NUM_TYPES = 3;
  localparam int unsigned NUM_THR   = 3;
  localparam int unsigned NUM_BANDS = NUM_THR + 1;

  typedef enum logic [1:0] {
    FT_INTRA = 2'd0,
    FT_PRED  = 2'd1,
    FT_BIP   = 2'd2,
    FT_RSV   = 2'd3
  } ftype_e;
endpackage

// File: rtl/band_lookup.sv
module band_lookup
  import frame_step_pkg::*;
#(
  parameter int unsigned SIZE_W = 20,
  parameter int unsigned STEP_W = 3
) (
  input  logic [SIZE_W-1:0]           size_i,
  input  logic [NUM_THR*SIZE_W-1:0]   thr_i,
  input  logic [NUM_BANDS*STEP_W-1:0] steps_i,
  output logic [STEP_W-1:0]           step_o
);
  localparam int unsigned BAND_W = $clog2(NUM_BANDS);

  logic [NUM_THR-1:0] hit;
  logic [BAND_W-1:0]  band;

  for (genvar k = 0; k < NUM_THR; k++) begin : g_cmp
    assign hit[k] = (size_i >= thr_i[k*SIZE_W +: SIZE_W]);
  end

  always_comb begin
    band = '0;
    for (int k = 0; k < NUM_THR; k++) begin
      band = band + BAND_W'(hit[k]);
    end
  end

  assign step_o = steps_i[band*STEP_W +: STEP_W];
endmodule

// File: rtl/miss_meter.sv
module miss_meter #(
  parameter int unsigned PER_W  = 16,
  parameter int unsigned MISS_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic              tick_i,
  input  logic              done_i,
  input  logic [PER_W-1:0]  period_i,
  output logic [MISS_W-1:0] miss_o
);
  logic [PER_W-1:0]  elapsed_q, elapsed_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic [MISS_W:0]   sum;
  logic [MISS_W-1:0] over;
  logic              elapsed_en, miss_en;

  always_comb begin
    elapsed_en = start_i | (busy_i & tick_i & ~(&elapsed_q));
    elapsed_d  = start_i ? '0 : elapsed_q + 1'b1;
    over       = (elapsed_q > period_i) ? MISS_W'(elapsed_q - period_i) : '0;
    sum        = {1'b0, miss_q} + {1'b0, over};
    miss_en    = done_i;
    miss_d     = sum[MISS_W] ? '1 : sum[MISS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed_q <= '0;
      miss_q    <= '0;
    end else begin
      if (elapsed_en) elapsed_q <= elapsed_d;
      if (miss_en)    miss_q    <= miss_d;
    end
  end

  assign miss_o = miss_q;

  // R6
  miss_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q >= $past(miss_q));
  // R8
  miss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(miss_q));
endmodule

// File: rtl/frame_step_sel.sv
module frame_step_sel
  import frame_step_pkg::*;
#(
  parameter int unsigned SIZE_W = 20,
  parameter int unsigned STEP_W = 3,
  parameter int unsigned PER_W  = 16,
  parameter int unsigned MISS_W = 32
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  hint_valid_i,
  output logic                                  hint_ready_o,
  input  logic [1:0]                            hint_type_i,
  input  logic [SIZE_W-1:0]                     hint_size_i,
  input  logic                                  hint_last_i,
  input  logic                                  done_i,
  input  logic                                  tick_i,
  input  logic [PER_W-1:0]                      period_i,
  input  logic [NUM_TYPES*NUM_THR*SIZE_W-1:0]   thr_i,
  input  logic [NUM_TYPES*NUM_BANDS*STEP_W-1:0] step_tbl_i,
  output logic                                  req_valid_o,
  output logic [STEP_W-1:0]                     req_step_o,
  output logic [STEP_W-1:0]                     cur_step_o,
  output logic [MISS_W-1:0]                     miss_total_o
);
  localparam int unsigned THR_SLICE  = NUM_THR * SIZE_W;
  localparam int unsigned STEP_SLICE = NUM_BANDS * STEP_W;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // per-type lookups
  logic [STEP_W-1:0] type_step [NUM_TYPES];
  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    band_lookup #(.SIZE_W(SIZE_W), .STEP_W(STEP_W)) u_lookup (
      .size_i  (hint_size_i),
      .thr_i   (thr_i[t*THR_SLICE +: THR_SLICE]),
      .steps_i (step_tbl_i[t*STEP_SLICE +: STEP_SLICE]),
      .step_o  (type_step[t])
    );
  end

  logic [STEP_W-1:0] bip_step, new_step;
  always_comb begin
    bip_step = (type_step[FT_BIP] > type_step[FT_PRED]) ? type_step[FT_BIP]
                                                        : type_step[FT_PRED];
    case (ftype_e'(hint_type_i))
      FT_INTRA: new_step = type_step[FT_INTRA];
      FT_PRED:  new_step = type_step[FT_PRED];
      default:  new_step = bip_step;
    endcase
  end

  // control state
  logic              busy_q, busy_d, last_q, last_d, req_q, req_d;
  logic [STEP_W-1:0] cur_q, cur_d, rstep_q, rstep_d;
  logic              accept, done_ev;

  assign accept  = hint_valid_i & ~busy_q;
  assign done_ev = done_i & busy_q;

  always_comb begin
    busy_d  = busy_q;
    last_d  = last_q;
    cur_d   = cur_q;
    rstep_d = rstep_q;
    req_d   = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      last_d = hint_last_i;
      if (new_step != cur_q) begin
        req_d   = 1'b1;
        rstep_d = new_step;
        cur_d   = new_step;
      end
    end else if (done_ev) begin
      busy_d = 1'b0;
      if (last_q && (cur_q != '0)) begin
        req_d   = 1'b1;
        rstep_d = '0;
        cur_d   = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
      cur_q   <= '0;
      rstep_q <= '0;
      req_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      last_q  <= last_d;
      cur_q   <= cur_d;
      rstep_q <= rstep_d;
      req_q   <= req_d;
    end
  end

  miss_meter #(.PER_W(PER_W), .MISS_W(MISS_W)) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .start_i  (accept),
    .busy_i   (busy_q),
    .tick_i   (tick_i),
    .done_i   (done_ev),
    .period_i (period_i),
    .miss_o   (miss_total_o)
  );

  assign hint_ready_o = ~busy_q & rst_n;
  assign req_valid_o  = req_q;
  assign req_step_o   = rstep_q;
  assign cur_step_o   = cur_q;

  // R4
  step_change_req_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |-> (req_q && rstep_q == cur_q));
  // R5
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hint_valid_i && hint_ready_o) |=> !hint_ready_o);
  // R7
  last_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_i && busy_q && last_q) |=> (cur_q == '0));
  // R8
  idle_done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_i && !busy_q && !hint_valid_i) |=> (!req_q && $stable(cur_q)));
endmodule

// File: tb/frame_step_sel_bench.sv
module frame_step_sel_bench;
  localparam int SIZE_W = 8;
  localparam int STEP_W = 3;
  localparam int PER_W  = 16;
  localparam int MISS_W = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int PERIOD_TICKS = 5;

  logic clk = 1'b0;
  logic rst_ni;
  logic hint_valid, hint_ready, hint_last, done, tick;
  logic [1:0] hint_type;
  logic [SIZE_W-1:0] hint_size;
  logic [PER_W-1:0] period;
  logic [9*SIZE_W-1:0] thr_flat;
  logic [12*STEP_W-1:0] stp_flat;
  logic req_valid;
  logic [STEP_W-1:0] req_step, cur_step;
  logic [MISS_W-1:0] miss_total;

  int tests = 0, fails = 0;
  int thr [3][3];
  int stp [3][4];
  int exp_cur = 0;
  longint exp_miss = 0;
  bit wd_hit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_step_sel #(.SIZE_W(SIZE_W), .STEP_W(STEP_W), .PER_W(PER_W), .MISS_W(MISS_W)) u_frame_step_sel (
    .clk_i(clk), .rst_ni(rst_ni), .hint_valid_i(hint_valid), .hint_ready_o(hint_ready),
    .hint_type_i(hint_type), .hint_size_i(hint_size), .hint_last_i(hint_last),
    .done_i(done), .tick_i(tick), .period_i(period), .thr_i(thr_flat),
    .step_tbl_i(stp_flat), .req_valid_o(req_valid), .req_step_o(req_step),
    .cur_step_o(cur_step), .miss_total_o(miss_total)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lookup(input int t, input int s);
    int b = 0;
    for (int k = 0; k < 3; k++) if (s >= thr[t][k]) b++;
    return stp[t][b];
  endfunction

  function automatic int model_step(input int t, input int s);
    int p, q;
    if (t == 0) return lookup(0, s);
    if (t == 1) return lookup(1, s);
    p = lookup(2, s);
    q = lookup(1, s);
    return (p > q) ? p : q;
  endfunction

  task automatic run_frame(input int t, input int s, input bit last, input int n, input bit poke);
    int es;
    bit ch;
    es = model_step(t, s);
    ch = (es != exp_cur);
    hint_valid = 1; hint_type = 2'(t); hint_size = SIZE_W'(s); hint_last = last;
    @(negedge clk);
    hint_valid = 0;
    check("R4 req strobe", req_valid, ch);
    check("R2/R3 step", cur_step, es);
    if (ch) check("R4 req step", req_step, es);
    check("R5 ready low", hint_ready, 0);
    exp_cur = es;
    if (poke) begin
      hint_valid = 1; hint_type = 2'(t ^ 1); hint_size = ~SIZE_W'(s); hint_last = 1;
      @(negedge clk);
      hint_valid = 0;
      check("R5 busy hint ignored step", cur_step, exp_cur);
      check("R5 busy hint no req", req_valid, 0);
    end
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0;
    end
    done = 1; @(negedge clk); done = 0;
    if (n > PERIOD_TICKS) exp_miss += n - PERIOD_TICKS;
    check("R6 miss total", miss_total, exp_miss);
    check("R5 ready after done", hint_ready, 1);
    if (last) begin
      check("R7 idle step", cur_step, 0);
      check("R7 idle req", req_valid, exp_cur != 0);
      exp_cur = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 40000);
    wd_hit = 1;
  end

  initial begin : main
    thr = '{'{40, 120, 200}, '{30, 90, 160}, '{60, 100, 220}};
    stp = '{'{2, 4, 5, 7}, '{0, 1, 3, 6}, '{1, 2, 2, 5}};
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < 3; k++) thr_flat[(t*3+k)*SIZE_W +: SIZE_W] = SIZE_W'(thr[t][k]);
      for (int b = 0; b < 4; b++) stp_flat[(t*4+b)*STEP_W +: STEP_W] = STEP_W'(stp[t][b]);
    end
    period = PER_W'(PERIOD_TICKS);
    hint_valid = 0; hint_type = 0; hint_size = 0; hint_last = 0; done = 0; tick = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    // R1
    check("R1 reset step", cur_step, 0);
    check("R1 reset req", req_valid, 0);
    check("R1 reset miss", miss_total, 0);
    check("R1 reset ready", hint_ready, 1);
    // R8 stray done while idle
    done = 1; @(negedge clk); done = 0; @(negedge clk);
    check("R8 idle done miss", miss_total, 0);
    check("R8 idle done req", req_valid, 0);
    check("R8 idle done step", cur_step, 0);
    // sweep all type codes and sizes
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 256; s++) begin
        if (wd_hit) break;
        run_frame(t, s, (t == 3 && s == 255), (s * 7 + t) % 9, (s % 64) == 3);
      end
    end
    // R8 after run: stray done again
    done = 1; @(negedge clk); done = 0; @(negedge clk);
    check("R8 stray done miss", miss_total, exp_miss);
    check("R8 stray done req", req_valid, 0);
    // R7 last frame already at step 0: no request
    run_frame(1, 0, 1, 2, 0);
    if (wd_hit) check("watchdog", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule